// File: doc/BRIEF.md
# Flush-to-zero single-precision floating-point multiplier

This block multiplies two IEEE-754 binary32 operands in a shader-style datapath. Subnormal numbers are not supported. An operand whose exponent field is zero is read as a zero of its own sign. A product too small to be normal is written as a signed zero. Because of these two rules, the raw significand product always lies between 1.0 and just below 4.0. Normalization therefore needs only a one-place right shift. No leading-zero counter and no wide left shifter are required.

The operands enter with a valid strobe. Three register stages follow:

1. Decode the operands, take the sign, and add the exponents.
2. Form the full 24x24-bit significand product.
3. Normalize, round to nearest-even, and repack.

The product leaves with its own valid strobe after a fixed three-cycle latency. Each stage loads only when its incoming valid is high, so idle cycles leave the data registers untouched. A new operand pair can be accepted on every clock.

Top module: `sp_ftz_mul`

## Requirements
- R1: The result sign is the XOR of the two operand signs, and this holds for zero and infinity results as well; only NaN results ignore it.
- R2: For two normal operands, the 24-bit significand product keeps its top 24 bits and rounds the remainder to nearest, ties to even (the half-way case rounds up only when the kept least significant bit is 1).
- R3: When the significand product is 2.0 or more, the significand is shifted right by one place and the exponent is raised by one (for example 1.5 x 1.5 gives 0x40100000).
- R4: When rounding carries the significand up to 2.0, the result becomes 1.0 with the exponent raised by one more (0x3FA1E58F x 0x3FCA6691 gives exactly 0x40000000).
- R5: A final biased exponent of 255 or more, counted after both normalization steps, gives infinity with the sign from R1 (bits 30:23 all ones, bits 22:0 zero). The largest normal value times 1.0 is returned unchanged.
- R6: A final biased exponent of 0 or less gives a zero with the sign from R1. No output ever has a zero exponent field with a nonzero fraction. The smallest normal value times 1.0 is returned unchanged.
- R7: An operand with exponent field 0 counts as zero, whatever its fraction. Any product with such an operand and a finite other operand is a zero with the sign from R1.
- R8: If either operand is a NaN (exponent 255, fraction nonzero), or infinity meets a zero or subnormal operand, the result is exactly 0x7FC00000.
- R9: Infinity times a nonzero value that is not a NaN gives infinity with the sign from R1.
- R10: A product appears on out_data with out_valid high exactly three rising edges after its operands were taken with in_valid high. out_valid is never high without such an input, and out_data holds its value while out_valid is low.
- R11: Asserting rst_n low clears out_valid at once and discards every operation in flight. After reset is released, no result emerges until new operands are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| in_valid | input | 1 | High when in_a and in_b hold an operand pair to multiply |
| in_a | input | 32 | First binary32 operand |
| in_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | High for one cycle per completed product |
| out_data | output | 32 | Binary32 product, valid while out_valid is high |

## Verification
Hand-picked operand pairs separate the datapath branches:

- products below 2.0 and at or above 2.0 distinguish the normalization shift;
- tie cases with odd and with even kept bits distinguish round-to-nearest-even from round-half-up and from truncation;
- a product of exactly 2^47-1 forces the rounding carry to 2.0;
- operand pairs at the edges of the exponent range separate overflow, underflow and the largest and smallest normals kept intact;
- each pairing of NaN, infinity, zero and subnormal with the others tells the special-value priorities apart.

Random operands with biased exponent fields, issued with irregular valid gaps, then test the rounding and exponent arithmetic against a reference that finds the leading bit and compares the remainder with one half. A reset in the middle of a stream checks that queued operations are dropped.

// File: rtl/sp_ftz_pkg.sv
package sp_ftz_pkg;

  // Operand-pair class decided in the first stage; it selects the result
  // kind in the last stage.
  typedef enum logic [1:0] {
    CLS_FINITE = 2'd0,
    CLS_ZERO   = 2'd1,
    CLS_INF    = 2'd2,
    CLS_NAN    = 2'd3
  } ftz_cls_e;

endpackage

// File: rtl/sp_ftz_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on the clock.
module sp_ftz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/sp_ftz_unpack.sv
// Operand decode: field split, subnormal-as-zero, pair classification,
// sign and unbiased exponent sum.
module sp_ftz_unpack
  import sp_ftz_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  output logic                        res_sign,
  output ftz_cls_e                    res_cls,
  output logic signed [EXP_W+2:0]     exp_sum,
  output logic [FRAC_W:0]             sig_a,
  output logic [FRAC_W:0]             sig_b
);

  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int ESUM_W = EXP_W + 3;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  logic [WORD_W-1:0] op_w   [2];
  logic [EXP_W-1:0]  exp_f  [2];
  logic [FRAC_W-1:0] frac_f [2];
  logic [SIG_W-1:0]  sig_f  [2];
  logic [1:0]        is_zero;
  logic [1:0]        is_inf;
  logic [1:0]        is_nan;

  assign op_w[0] = op_a;
  assign op_w[1] = op_b;

  // Identical decode for each operand.
  for (genvar g = 0; g < 2; g++) begin : g_opdec
    assign exp_f[g]   = op_w[g][WORD_W-2 -: EXP_W];
    assign frac_f[g]  = op_w[g][FRAC_W-1:0];
    assign is_zero[g] = (exp_f[g] == '0);            // zero or subnormal
    assign is_inf[g]  = (&exp_f[g]) && (frac_f[g] == '0);
    assign is_nan[g]  = (&exp_f[g]) && (frac_f[g] != '0);
    assign sig_f[g]   = {1'b1, frac_f[g]};
  end

  assign sig_a    = sig_f[0];
  assign sig_b    = sig_f[1];
  assign res_sign = op_a[WORD_W-1] ^ op_b[WORD_W-1];

  always_comb begin
    if ((|is_nan) || ((|is_inf) && (|is_zero))) res_cls = CLS_NAN;
    else if (|is_inf)                           res_cls = CLS_INF;
    else if (|is_zero)                          res_cls = CLS_ZERO;
    else                                        res_cls = CLS_FINITE;
  end

  assign exp_sum = $signed(ESUM_W'(exp_f[0]) + ESUM_W'(exp_f[1]) - ESUM_W'(BIAS));

endmodule

// File: rtl/sp_ftz_round.sv
// Final stage logic: one-place normalize, round to nearest-even,
// renormalize on carry, range check and repack.
module sp_ftz_round
  import sp_ftz_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [2*FRAC_W+1:0]      prod,
  input  logic signed [EXP_W+2:0]  exp_sum,
  input  logic                     res_sign,
  input  ftz_cls_e                 res_cls,
  output logic [EXP_W+FRAC_W:0]    result
);

  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int ESUM_W = EXP_W + 3;
  localparam logic signed [ESUM_W-1:0] E_FLOOR = '0;
  localparam logic signed [ESUM_W-1:0] E_CEIL  = ESUM_W'((1 << EXP_W) - 1);
  localparam logic [EXP_W+FRAC_W:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                     hi;
  logic [PROD_W-1:0]        aligned;
  logic [SIG_W-1:0]         kept;
  logic                     guard;
  logic                     sticky;
  logic                     round_up;
  logic [SIG_W:0]           rounded;
  logic                     carry;
  logic [SIG_W-1:0]         norm;
  logic signed [ESUM_W-1:0] exp_fin;
  logic                     ovf;
  logic                     unf;

  always_comb begin
    hi       = prod[PROD_W-1];
    aligned  = hi ? prod : (prod << 1);
    kept     = aligned[PROD_W-1 -: SIG_W];
    guard    = aligned[PROD_W-1-SIG_W];
    sticky   = |aligned[PROD_W-2-SIG_W:0];
    round_up = guard & (sticky | kept[0]);
    rounded  = {1'b0, kept} + (SIG_W+1)'(round_up);
    carry    = rounded[SIG_W];
    norm     = carry ? rounded[SIG_W:1] : rounded[SIG_W-1:0];
    exp_fin  = exp_sum + $signed(ESUM_W'(hi)) + $signed(ESUM_W'(carry));
    ovf      = (exp_fin >= E_CEIL);
    unf      = (exp_fin <= E_FLOOR) || !norm[SIG_W-1];
  end

  always_comb begin
    unique case (res_cls)
      CLS_NAN:  result = QNAN;
      CLS_INF:  result = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_ZERO: result = {res_sign, {(EXP_W+FRAC_W){1'b0}}};
      default: begin
        if (ovf)      result = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (unf) result = {res_sign, {(EXP_W+FRAC_W){1'b0}}};
        else          result = {res_sign, exp_fin[EXP_W-1:0], norm[FRAC_W-1:0]};
      end
    endcase
  end

endmodule

// File: rtl/sp_ftz_mul.sv
// Three-stage flush-to-zero binary floating-point multiplier.
module sp_ftz_mul
  import sp_ftz_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [EXP_W+FRAC_W:0]    in_a,
  input  logic [EXP_W+FRAC_W:0]    in_b,
  output logic                     out_valid,
  output logic [EXP_W+FRAC_W:0]    out_data
);

  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int ESUM_W = EXP_W + 3;

  logic rst_sync_n;

  sp_ftz_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // ---------------- stage 1: decode ----------------
  logic                     dec_sign;
  ftz_cls_e                 dec_cls;
  logic signed [ESUM_W-1:0] dec_exp;
  logic [SIG_W-1:0]         dec_sig_a;
  logic [SIG_W-1:0]         dec_sig_b;

  sp_ftz_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .op_a     (in_a),
    .op_b     (in_b),
    .res_sign (dec_sign),
    .res_cls  (dec_cls),
    .exp_sum  (dec_exp),
    .sig_a    (dec_sig_a),
    .sig_b    (dec_sig_b)
  );

  logic                     s1_valid_q, s1_valid_d;
  logic                     s1_sign_q,  s1_sign_d;
  ftz_cls_e                 s1_cls_q,   s1_cls_d;
  logic signed [ESUM_W-1:0] s1_exp_q,   s1_exp_d;
  logic [SIG_W-1:0]         s1_sa_q,    s1_sa_d;
  logic [SIG_W-1:0]         s1_sb_q,    s1_sb_d;

  always_comb begin
    s1_valid_d = in_valid;
    s1_sign_d  = in_valid ? dec_sign  : s1_sign_q;
    s1_cls_d   = in_valid ? dec_cls   : s1_cls_q;
    s1_exp_d   = in_valid ? dec_exp   : s1_exp_q;
    s1_sa_d    = in_valid ? dec_sig_a : s1_sa_q;
    s1_sb_d    = in_valid ? dec_sig_b : s1_sb_q;
  end

  // ---------------- stage 2: significand product ----------------
  logic                     s2_valid_q, s2_valid_d;
  logic                     s2_sign_q,  s2_sign_d;
  ftz_cls_e                 s2_cls_q,   s2_cls_d;
  logic signed [ESUM_W-1:0] s2_exp_q,   s2_exp_d;
  logic [PROD_W-1:0]        s2_prod_q,  s2_prod_d;
  logic [PROD_W-1:0]        mul_full;

  assign mul_full = PROD_W'(s1_sa_q) * PROD_W'(s1_sb_q);

  always_comb begin
    s2_valid_d = s1_valid_q;
    s2_sign_d  = s1_valid_q ? s1_sign_q : s2_sign_q;
    s2_cls_d   = s1_valid_q ? s1_cls_q  : s2_cls_q;
    s2_exp_d   = s1_valid_q ? s1_exp_q  : s2_exp_q;
    s2_prod_d  = s1_valid_q ? mul_full  : s2_prod_q;
  end

  // ---------------- stage 3: round and pack ----------------
  logic [WORD_W-1:0] packed_res;
  logic              s3_valid_q, s3_valid_d;
  logic [WORD_W-1:0] s3_data_q,  s3_data_d;

  sp_ftz_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .prod     (s2_prod_q),
    .exp_sum  (s2_exp_q),
    .res_sign (s2_sign_q),
    .res_cls  (s2_cls_q),
    .result   (packed_res)
  );

  always_comb begin
    s3_valid_d = s2_valid_q;
    s3_data_d  = s2_valid_q ? packed_res : s3_data_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      s3_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
      s3_valid_q <= s3_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    s1_sign_q <= s1_sign_d;
    s1_cls_q  <= s1_cls_d;
    s1_exp_q  <= s1_exp_d;
    s1_sa_q   <= s1_sa_d;
    s1_sb_q   <= s1_sb_d;
    s2_sign_q <= s2_sign_d;
    s2_cls_q  <= s2_cls_d;
    s2_exp_q  <= s2_exp_d;
    s2_prod_q <= s2_prod_d;
    s3_data_q <= s3_data_d;
  end

  assign out_valid = s3_valid_q;
  assign out_data  = s3_data_q;

endmodule

// File: rtl/sp_ftz_mul_chk.sv
// Property checker, attached to every instance of the multiplier.
module sp_ftz_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] in_a,
  input logic [EXP_W+FRAC_W:0] in_b,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_data
);

  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic out_is_nan;
  assign out_is_nan = (&out_data[WORD_W-2 -: EXP_W]) && (out_data[FRAC_W-1:0] != '0);

  // R10: every accepted pair comes out three edges later
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  // R10: no result without an input three edges earlier
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  // R10: data holds while no result is presented
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R8: any NaN leaving the block is the canonical quiet one
  p_canon_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_nan) |-> (out_data == QNAN));

  // R6: subnormal encodings never leave the block
  p_no_subnormal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((out_data[WORD_W-2 -: EXP_W] == '0) && (out_data[FRAC_W-1:0] != '0)));

  // R1: non-NaN result sign follows the operand signs
  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_nan) |->
      (out_data[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1], 3)));

endmodule

bind sp_ftz_mul sp_ftz_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_sp_ftz_mul.sv
`timescale 1ns/1ps
module tb_sp_ftz_mul;

  localparam real HALF_NS = 2.5;   // 200 MHz

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic        out_valid;
  logic [31:0] out_data;

  int checks;
  int fails;
  bit done;

  // Bench-side expectation pipeline: entry pushed at a falling edge is due
  // three falling edges later.
  logic        d1v, d2v, d3v;
  logic [31:0] d1e, d2e, d3e;
  string       d1t, d2t, d3t;

  sp_ftz_mul dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #(HALF_NS) clk = ~clk;

  // Reference product: locate the leading bit, compare the discarded part
  // with one half, treat exponent-0 encodings as zero.
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, e, sh;
    bit za, zb, ia, ib, na, nb;
    longint unsigned p, q, rem, half;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    za = (ea == 0);
    zb = (eb == 0);
    ia = (ea == 255) && (a[22:0] == 0);
    ib = (eb == 255) && (b[22:0] == 0);
    na = (ea == 255) && (a[22:0] != 0);
    nb = (eb == 255) && (b[22:0] != 0);
    if (na || nb || (ia && zb) || (ib && za)) return 32'h7FC00000;
    if (ia || ib) return {s, 8'hFF, 23'h0};
    if (za || zb) return {s, 31'h0};
    p  = 64'({1'b1, a[22:0]}) * 64'({1'b1, b[22:0]});
    e  = ea + eb - 127;
    sh = 23;
    if (p >= (64'd1 << 47)) begin
      sh = 24;
      e  = e + 1;
    end
    q    = p >> sh;
    rem  = p - (q << sh);
    half = 64'd1 << (sh - 1);
    if ((rem > half) || ((rem == half) && q[0])) q = q + 1;
    if (q == (64'd1 << 24)) begin
      q = q >> 1;
      e = e + 1;
    end
    if (e >= 255) return {s, 8'hFF, 23'h0};
    if (e <= 0)   return {s, 31'h0};
    return {s, e[7:0], q[22:0]};
  endfunction

  function automatic logic [31:0] rand_op();
    logic [31:0] r;
    int sel;
    r   = $urandom;
    sel = int'($urandom % 8);
    case (sel)
      0: r[30:23] = 8'h00;
      1: r[30:23] = 8'hFF;
      2: r[30:23] = 8'(1 + ($urandom % 3));
      3: r[30:23] = 8'(250 + ($urandom % 5));
      4: r[30:23] = 8'(40 + ($urandom % 30));
      5: r[30:23] = 8'(185 + ($urandom % 30));
      default: ;
    endcase
    if (sel == 1 && ($urandom % 2) == 0) r[22:0] = 23'h0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] e, input string tag);
    @(negedge clk);
    chk(out_valid === d3v, "R10 valid timing", 32'(out_valid), 32'(d3v));
    if (d3v) chk(out_data === d3e, d3t, out_data, d3e);
    d3v = d2v; d3e = d2e; d3t = d2t;
    d2v = d1v; d2e = d1e; d2t = d1t;
    d1v = v;   d1e = e;   d1t = tag;
    in_valid = v;
    in_a     = a;
    in_b     = b;
  endtask

  task automatic dir(input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] e, input string tag);
    step(1'b1, a, b, e, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 32'h0, 32'h0, "R10 idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(HALF_NS * 2.0 * 150000.0);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    d1v = 0; d2v = 0; d3v = 0;
    d1e = 0; d2e = 0; d3e = 0;
    d1t = ""; d2t = ""; d3t = "";
    rst_n = 1'b0; in_valid = 1'b0; in_a = 0; in_b = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0, "R11 reset state", 32'(out_valid), 32'h0);

    // R2 rounding, ties to even
    dir(32'h3F800000, 32'h3F800000, 32'h3F800000, "R2 one times one");
    dir(32'h3F800001, 32'h3FC00000, 32'h3FC00002, "R2 tie odd rounds up");
    dir(32'h3F800003, 32'h3FC00000, 32'h3FC00004, "R2 tie even stays");
    // R3 normalization shift
    dir(32'h3FC00000, 32'h3FC00000, 32'h40100000, "R3 1.5 squared");
    dir(32'h40400000, 32'h40400000, 32'h41100000, "R3 3 squared");
    dir(32'hBFC00000, 32'h3FC00000, 32'hC0100000, "R1 negative product");
    // R4 rounding carry to 2.0
    dir(32'h3FA1E58F, 32'h3FCA6691, 32'h40000000, "R4 carry to two");
    // R5 overflow
    dir(32'h7F000000, 32'h40000000, 32'h7F800000, "R5 overflow");
    dir(32'hFF000000, 32'h40000000, 32'hFF800000, "R5 negative overflow");
    dir(32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, "R5 max normal kept");
    dir(32'h7F7FFFFF, 32'h3F800001, 32'h7F800000, "R5 overflow after shift");
    // R6 underflow
    dir(32'h00800000, 32'h3F000000, 32'h00000000, "R6 underflow");
    dir(32'h80800000, 32'h3F000000, 32'h80000000, "R6 negative underflow");
    dir(32'h00800000, 32'h3F800000, 32'h00800000, "R6 min normal kept");
    // R7 subnormal and zero operands
    dir(32'h00000001, 32'h7F000000, 32'h00000000, "R7 subnormal operand");
    dir(32'h80400000, 32'h3F800000, 32'h80000000, "R7 negative subnormal");
    dir(32'h00000000, 32'hC0000000, 32'h80000000, "R7 signed zero");
    // R8 NaN cases
    dir(32'h7FC00001, 32'h3F800000, 32'h7FC00000, "R8 NaN input");
    dir(32'hFF800001, 32'h00000000, 32'h7FC00000, "R8 NaN with zero");
    dir(32'h7F800000, 32'h00000000, 32'h7FC00000, "R8 inf times zero");
    dir(32'h7F800000, 32'h00000001, 32'h7FC00000, "R8 inf times subnormal");
    dir(32'h80000000, 32'hFF800000, 32'h7FC00000, "R8 zero times inf");
    // R9 infinity
    dir(32'h7F800000, 32'hC0000000, 32'hFF800000, "R9 inf times finite");
    dir(32'hFF800000, 32'hFF800000, 32'h7F800000, "R9 inf times inf");
    idle(4);

    // Random stream with gaps
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      logic        rv;
      ra = rand_op();
      rb = rand_op();
      rv = (($urandom % 4) != 0);
      step(rv, ra, rb, ref_mul(ra, rb), "R2 random operands");
    end
    idle(4);

    // R11: reset in the middle of a stream drops queued work
    step(1'b1, 32'h3F800000, 32'h40000000, 32'h40000000, "R11 queued");
    step(1'b1, 32'h40000000, 32'h40000000, 32'h40800000, "R11 queued");
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    d1v = 0; d2v = 0; d3v = 0;
    #1;
    chk(out_valid === 1'b0, "R11 valid cleared", 32'(out_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R11 nothing after reset", 32'(out_valid), 32'h0);
    end
    dir(32'h40000000, 32'h40400000, 32'h40C00000, "R11 resume");
    idle(4);

    finish_run();
  end

endmodule